// File: doc/BRIEF.md
# Paired-Timer Watchdog with Four-Stage Expiry

This peripheral guards a system by counting down a programmable number of ticks from its own periodic timer. The timer counts a 1 MHz reference, made by dividing the core clock by a parameter, down from a programmed load value. Each expiry of that timer is a watchdog tick, but only when the configured timer selector matches the pairing parameter. When the watchdog countdown runs out, an expiration is logged and the countdown starts again from the configured period. The block can pulse an interrupt on every expiration. On the fourth expiration it can assert a system reset request, which stays asserted.

Software starts the watchdog, or kicks it, by writing the start bit of the command register. Stopping it takes two writes: the unlock key goes to the key register, and then the stop bit goes to the command register. Reads are combinational on the same bus. Word offsets: 0x00 configuration, 0x04 status, 0x08 command, 0x0C key, 0x10 timer.

Top module: `wdog_pair`

## Requirements
- R1: After reset, the configuration, status and timer registers read 0, and `irqPulse` and `sysRstReq` are low.
- R2: Configuration at 0x00 reads back as follows: selector in [3:0], period in [11:4], interrupt enable in bit 12, reset enable in bit 15. All other bits read 0.
- R3: Timer register at 0x10: bit 31 enables, bit 30 selects periodic reload, and [28:0] holds the load value L. A write restarts the reference divider. The first timer expiry then comes L·TICK_DIV clocks after the write edge, and periodic expiries follow at the same spacing.
- R4: While running, each watchdog tick decrements the countdown. Status at 0x04 shows the countdown in [11:4] and the expiration count in [13:12]. A tick that finds the countdown at 1 or below is an expiration: the countdown reloads from the period, and the expiration count rises, saturating at 3.
- R5: Writing bit 0 to the command register at 0x08 makes the watchdog run, reloads the countdown from the period and clears the expiration count.
- R6: Writing bit 1 to the command register stops the countdown, but only if the last key write since the previous command write was 0x0000C45A. Any command write clears the unlock.
- R7: When interrupt enable is set, `irqPulse` is high for one cycle after each expiration edge.
- R8: When reset enable is set, `sysRstReq` rises on the fourth expiration and holds until `rstN` is asserted, even across an unlocked stop.
- R9: With bit 30 clear, the timer expires once, clears its own enable bit and produces no further ticks.
- R10: When the selector differs from PAIR_ID, timer expiries do not change the countdown.
- R11: If a start command and an expiring tick land in the same cycle, the start wins. There is no expiration and no interrupt, and the countdown holds the full period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busWe | input | 1 | Write strobe |
| busAddr | input | 5 | Byte offset of the register |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Combinational read data |
| irqPulse | output | 1 | One-cycle interrupt per expiration |
| sysRstReq | output | 1 | Sticky system reset request |

## Verification
The collision of note is a kick from software that arrives on the very edge where a timer expiry would end the countdown. The bench counts clocks from the timer write, because that write aligns the reference divider. It then places the start write so that the bus captures it on that expiry edge. The bench passes the design only if the status shows the expiration count unchanged with a full countdown, and no interrupt appears. The next natural expiration must then arrive one full period later.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int ADDR_W = 5;
  localparam logic [ADDR_W-1:0] OFS_CFG = 5'h00;
  localparam logic [ADDR_W-1:0] OFS_STS = 5'h04;
  localparam logic [ADDR_W-1:0] OFS_CMD = 5'h08;
  localparam logic [ADDR_W-1:0] OFS_KEY = 5'h0C;
  localparam logic [ADDR_W-1:0] OFS_TMR = 5'h10;
  localparam logic [31:0] UNLOCK_KEY = 32'h0000_C45A;

  typedef struct packed {
    logic start;
    logic stop;
    logic tmrWr;
  } wdStrobe_t;

  typedef struct packed {
    logic [3:0] timerId;
    logic [7:0] period;
    logic       intEn;
    logic       rstEn;
  } wdCfg_t;
endpackage

// File: rtl/wdog_ctrl.sv
module wdog_ctrl
  import wdog_pkg::*;
#(
  parameter int TLOAD_W = 29
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               busWe,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [31:0]        busWdata,
  input  logic [7:0]         stsCount,
  input  logic [1:0]         stsExp,
  input  logic               tmrEn,
  input  logic               tmrPeriodic,
  input  logic [TLOAD_W-1:0] tmrLoad,
  output wdCfg_t             cfg,
  output wdStrobe_t          stb,
  output logic [31:0]        busRdata
);
  logic unlocked;
  logic cmdWr;
  logic [29:0] tmrLow;

  assign cmdWr = busWe && (busAddr == OFS_CMD);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfg      <= '0;
      unlocked <= 1'b0;
    end else begin
      if (busWe && busAddr == OFS_CFG) begin
        cfg.timerId <= busWdata[3:0];
        cfg.period  <= busWdata[11:4];
        cfg.intEn   <= busWdata[12];
        cfg.rstEn   <= busWdata[15];
      end
      if (cmdWr)
        unlocked <= 1'b0;
      else if (busWe && busAddr == OFS_KEY)
        unlocked <= (busWdata == UNLOCK_KEY);
    end
  end

  always_comb begin
    stb       = '0;
    stb.start = cmdWr && busWdata[0];
    stb.stop  = cmdWr && busWdata[1] && unlocked;
    stb.tmrWr = busWe && (busAddr == OFS_TMR);
  end

  assign tmrLow = 30'(tmrLoad);

  always_comb begin
    unique case (busAddr)
      OFS_CFG: busRdata = {16'b0, cfg.rstEn, 2'b0, cfg.intEn, cfg.period, cfg.timerId};
      OFS_STS: busRdata = {18'b0, stsExp, stsCount, 4'b0};
      OFS_TMR: busRdata = {tmrEn, tmrPeriodic, tmrLow};
      default: busRdata = 32'b0;
    endcase
  end

  // R6: a command write always consumes the unlock
  a_r6_unlock_consumed: assert property (@(posedge clk) disable iff (!rstN)
    cmdWr |=> !unlocked);
  // R2: configuration write lands in the period field
  a_r2_period_written: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && busAddr == OFS_CFG) |=> cfg.period == $past(busWdata[11:4]));
endmodule

// File: rtl/wdog_dp.sv
module wdog_dp
  import wdog_pkg::*;
#(
  parameter int TICK_DIV = 125,
  parameter int TLOAD_W  = 29,
  parameter int PAIR_ID  = 5
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [31:0]        busWdata,
  input  wdCfg_t             cfg,
  input  wdStrobe_t          stb,
  output logic [7:0]         countdown,
  output logic [1:0]         expCnt,
  output logic               tmrEn,
  output logic               tmrPeriodic,
  output logic [TLOAD_W-1:0] tmrLoad,
  output logic               irqPulse,
  output logic               sysRstReq
);
  localparam int DIV_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(TICK_DIV - 1);

  logic [DIV_W-1:0]   divCnt;
  logic               refPulse;
  logic [TLOAD_W-1:0] tmrRemain;
  logic               tmrExpire;
  logic               running;
  logic               wdTick;
  logic               expire;

  assign refPulse = (divCnt == DIV_LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                    divCnt <= '0;
    else if (stb.tmrWr || refPulse) divCnt <= '0;
    else                          divCnt <= divCnt + 1'b1;
  end

  assign tmrExpire = refPulse && tmrEn && (tmrRemain <= TLOAD_W'(1)) && !stb.tmrWr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tmrEn       <= 1'b0;
      tmrPeriodic <= 1'b0;
      tmrLoad     <= '0;
      tmrRemain   <= '0;
    end else if (stb.tmrWr) begin
      tmrEn       <= busWdata[31];
      tmrPeriodic <= busWdata[30];
      tmrLoad     <= busWdata[TLOAD_W-1:0];
      tmrRemain   <= busWdata[TLOAD_W-1:0];
    end else if (refPulse && tmrEn) begin
      if (tmrRemain <= TLOAD_W'(1)) begin
        tmrRemain <= tmrLoad;
        if (!tmrPeriodic) tmrEn <= 1'b0;
      end else begin
        tmrRemain <= tmrRemain - 1'b1;
      end
    end
  end

  assign wdTick = tmrExpire && running && (cfg.timerId == 4'(PAIR_ID));
  assign expire = wdTick && (countdown <= 8'd1) && !stb.start && !stb.stop;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      running   <= 1'b0;
      countdown <= '0;
      expCnt    <= '0;
    end else if (stb.stop) begin
      running <= 1'b0;
    end else if (stb.start) begin
      running   <= 1'b1;
      countdown <= cfg.period;
      expCnt    <= '0;
    end else if (wdTick) begin
      if (countdown <= 8'd1) begin
        countdown <= cfg.period;
        if (expCnt != 2'd3) expCnt <= expCnt + 1'b1;
      end else begin
        countdown <= countdown - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqPulse  <= 1'b0;
      sysRstReq <= 1'b0;
    end else begin
      irqPulse <= expire && cfg.intEn;
      if (expire && expCnt == 2'd3 && cfg.rstEn) sysRstReq <= 1'b1;
    end
  end

  // R8: reset request never drops before the global reset
  a_r8_rst_sticky: assert property (@(posedge clk) disable iff (!rstN)
    sysRstReq |=> sysRstReq);
  // R8: request only rises with reset enabled
  a_r8_rst_needs_en: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sysRstReq) |-> $past(cfg.rstEn));
  // R7: interrupt only with interrupt enable
  a_r7_irq_needs_en: assert property (@(posedge clk) disable iff (!rstN)
    irqPulse |-> $past(cfg.intEn));
  // R5: start reloads countdown and clears expirations
  a_r5_start_reload: assert property (@(posedge clk) disable iff (!rstN)
    (stb.start && !stb.stop) |=> (expCnt == 2'd0 && countdown == $past(cfg.period)));
  // R6: running only falls through an accepted stop
  a_r6_stop_only: assert property (@(posedge clk) disable iff (!rstN)
    $fell(running) |-> $past(stb.stop));
  // R9: one-shot timer disables itself after expiring
  a_r9_oneshot_off: assert property (@(posedge clk) disable iff (!rstN)
    (tmrExpire && !tmrPeriodic) |=> !tmrEn);
endmodule

// File: rtl/wdog_pair.sv
module wdog_pair
  import wdog_pkg::*;
#(
  parameter int TICK_DIV = 125,
  parameter int TLOAD_W  = 29,
  parameter int PAIR_ID  = 5
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        busWe,
  input  logic [4:0]  busAddr,
  input  logic [31:0] busWdata,
  output logic [31:0] busRdata,
  output logic        irqPulse,
  output logic        sysRstReq
);
  wdCfg_t             cfg;
  wdStrobe_t          stb;
  logic [7:0]         countdown;
  logic [1:0]         expCnt;
  logic               tmrEn;
  logic               tmrPeriodic;
  logic [TLOAD_W-1:0] tmrLoad;

  wdog_ctrl #(.TLOAD_W(TLOAD_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busAddr(busAddr),
    .busWdata(busWdata), .stsCount(countdown), .stsExp(expCnt),
    .tmrEn(tmrEn), .tmrPeriodic(tmrPeriodic), .tmrLoad(tmrLoad),
    .cfg(cfg), .stb(stb), .busRdata(busRdata)
  );

  wdog_dp #(.TICK_DIV(TICK_DIV), .TLOAD_W(TLOAD_W), .PAIR_ID(PAIR_ID)) u_dp (
    .clk(clk), .rstN(rstN), .busWdata(busWdata), .cfg(cfg), .stb(stb),
    .countdown(countdown), .expCnt(expCnt), .tmrEn(tmrEn),
    .tmrPeriodic(tmrPeriodic), .tmrLoad(tmrLoad),
    .irqPulse(irqPulse), .sysRstReq(sysRstReq)
  );
endmodule

// File: tb/wdog_pair_bench.sv
module wdog_pair_bench;
  localparam int P = 2;
  localparam logic [4:0] A_CFG = 5'h00, A_STS = 5'h04, A_CMD = 5'h08,
                         A_KEY = 5'h0C, A_TMR = 5'h10;
  localparam int NV = 5;
  localparam int V_PER [NV] = '{3, 1, 2, 4, 2};
  localparam int V_LD  [NV] = '{2, 1, 3, 1, 2};
  localparam int V_INT [NV] = '{1, 1, 0, 1, 1};
  localparam int V_RST [NV] = '{1, 1, 1, 0, 1};
  localparam int V_ID  [NV] = '{5, 5, 5, 5, 3};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busWe = 1'b0;
  logic [4:0] busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic irqPulse, sysRstReq;
  int nChecks = 0;
  int nFail = 0;

  always #4 clk = ~clk;

  wdog_pair #(.TICK_DIV(P)) u_wdog_pair (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata),
    .irqPulse(irqPulse), .sysRstReq(sysRstReq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    busWe = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busWe = 1'b0; busWdata = '0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    busAddr = a;
    #1;
    d = busRdata;
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog timeout");
    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
    $finish;
  end

  initial begin
    logic [31:0] r, c0;
    // R1 reset state
    doReset();
    rd(A_CFG, r); chk("R1 cfg", r, 0);
    rd(A_STS, r); chk("R1 sts", r, 0);
    rd(A_TMR, r); chk("R1 tmr", r, 0);
    chk("R1 outputs", {30'b0, irqPulse, sysRstReq}, 0);

    // R2 field readback with junk in reserved bits
    wr(A_CFG, 32'hFFFF_FAB5);
    rd(A_CFG, r); chk("R2 cfg readback", r, 32'h0000_9AB5);

    // table of full expiry runs: R3 R4 R5 R7 R8 R10
    for (int v = 0; v < NV; v++) begin
      int n, tPer, tAll, irqs, irqExp;
      logic match, rstExp;
      n = V_PER[v];
      tPer = V_PER[v] * V_LD[v] * P;
      tAll = 4 * tPer;
      match = (V_ID[v] == 5);
      rstExp = match && (V_RST[v] == 1);
      irqExp = (match && V_INT[v] == 1) ? 4 : 0;
      irqs = 0;
      doReset();
      wr(A_CFG, 32'((V_RST[v] << 15) | (V_INT[v] << 12) | (n << 4) | V_ID[v]));
      wr(A_CMD, 32'h1);
      rd(A_STS, r); chk("R5 start reload", r, 32'(n << 4));
      wr(A_TMR, 32'hC000_0000 | 32'(V_LD[v]));
      for (int c = 1; c <= tAll; c++) begin
        @(negedge clk);
        if (irqPulse) irqs++;
        if (c == tPer) begin
          rd(A_STS, r);
          chk(match ? "R4 first expiration" : "R10 selector mismatch",
              r, 32'(((match ? 1 : 0) << 12) | (n << 4)));
        end
        if (c == tAll - 1) chk("R8 no early reset (R3 timing)", {31'b0, sysRstReq}, 0);
        if (c == tAll) chk("R8 reset on 4th (R3 timing)", {31'b0, sysRstReq}, {31'b0, rstExp});
      end
      chk("R7 irq count", 32'(irqs), 32'(irqExp));
      if (rstExp) begin
        wr(A_KEY, 32'h0000_C45A);
        wr(A_CMD, 32'h2);
        repeat (5) @(negedge clk);
        chk("R8 held after stop", {31'b0, sysRstReq}, 1);
      end
    end
    doReset();
    chk("R1 reset clears request", {31'b0, sysRstReq}, 0);

    // R11 collision of start with an expiring tick
    wr(A_CFG, 32'h0000_1035);
    wr(A_CMD, 32'h1);
    wr(A_TMR, 32'hC000_0001);
    repeat (4) @(negedge clk);
    rd(A_STS, r); chk("R4 countdown before expiry", r, 32'h10);
    wr(A_CMD, 32'h1);
    chk("R11 no irq on collision", {31'b0, irqPulse}, 0);
    rd(A_STS, r); chk("R11 start wins", r, 32'h30);
    repeat (5) @(negedge clk);
    rd(A_STS, r); chk("R11 full period follows", r, 32'h10);
    @(negedge clk);
    rd(A_STS, r); chk("R4 expiration after kick", r, 32'h1030);
    chk("R7 irq after expiration", {31'b0, irqPulse}, 1);
    wr(A_CMD, 32'h1);
    rd(A_STS, r); chk("R5 start clears count", r, 32'h30);

    // R6 unlock rules
    doReset();
    wr(A_CFG, 32'h0000_0C85);
    wr(A_CMD, 32'h1);
    wr(A_TMR, 32'hC000_0001);
    wr(A_CMD, 32'h2);
    rd(A_STS, c0); repeat (10) @(negedge clk); rd(A_STS, r);
    chk("R6 stop without key ignored", r[11:4], c0[11:4] - 5);
    wr(A_KEY, 32'h0000_C45A);
    wr(A_CMD, 32'h1);
    wr(A_CMD, 32'h2);
    rd(A_STS, c0); repeat (10) @(negedge clk); rd(A_STS, r);
    chk("R6 key consumed by command", r[11:4], c0[11:4] - 5);
    wr(A_KEY, 32'h0000_1234);
    wr(A_CMD, 32'h2);
    rd(A_STS, c0); repeat (10) @(negedge clk); rd(A_STS, r);
    chk("R6 wrong key ignored", r[11:4], c0[11:4] - 5);
    wr(A_KEY, 32'h0000_C45A);
    wr(A_CMD, 32'h2);
    rd(A_STS, c0); repeat (10) @(negedge clk); rd(A_STS, r);
    chk("R6 unlocked stop freezes", r[11:4], c0[11:4]);

    // R9 one-shot timer
    doReset();
    wr(A_CFG, 32'h0000_0055);
    wr(A_CMD, 32'h1);
    wr(A_TMR, 32'h8000_0003);
    repeat (20) @(negedge clk);
    rd(A_STS, r); chk("R9 single tick", r, 32'h40);
    rd(A_TMR, r); chk("R9 enable cleared", r, 32'h0000_0003);

    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
    $finish;
  end
endmodule